// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames, one byte per beat, from a MAC receive stream and stores them in a circular byte ring held in an external memory. It writes that memory through a plain 32-bit word port with byte enables. Each frame is stored as a record: a 32-bit header word followed by the frame bytes. The header holds the byte count in its upper half and the status flags in its lower half. Records start on 4-byte boundaries, and a frame that runs past the top of the ring carries on at offset 0.

While a frame is being stored, its header reads a busy length of 0xFFF0. The real header is written only after the frame's last data word, so a consumer that walks the ring stops at an unfinished record. Software hands space back by writing a read-pointer register that is biased by 16. The block reports an empty flag and its committed write offset. It also gives one-cycle pulses for good and errored frames, and a counter of the frames it dropped because the ring lacked room.

Top module: `rxring_writer`

## Requirements
- R1: The final header word of a record holds the frame byte count, including the 4 FCS bytes, in bits 31:16. Bit 0 is set for a good frame and bit 1 is set when the MAC flagged an error. Bits 15:2 are zero.
- R2: When a frame is accepted, a header with length 0xFFF0 and status 0 is written at the record offset before any data word. The final header replaces it in the cycle after the write of the frame's last data word.
- R3: The next record starts at the header offset plus 4 plus the byte count, rounded up to a multiple of 4. `wrptr` moves to that offset only in the cycle the final header is written, and it is always a multiple of 4.
- R4: All offsets are taken modulo 2^RING_AW bytes. Frame bytes past the last ring byte continue at offset 0.
- R5: The read offset is `rdptr_q` + 16, modulo the ring size. `rdptr_q` resets to 0xFFF0 and takes `rdptr_wdata` on the cycle after `rdptr_we`.
- R6: `buf_empty` is 1 exactly when `wrptr` equals the read offset.
- R7: A frame is accepted only if (write offset − read offset) mod ring is less than ring − (4 + MAX_FRAME rounded up to 4), checked at its first byte. A refused frame causes no memory write. It raises `missed` by one, and `missed` saturates at its all-ones value.
- R8: `irq_ok` (good frame) or `irq_err` (errored frame) pulses for one cycle, in the cycle the final header is written, and never both at once.
- R9: The frame byte at ring offset o is written to word o/4, lane o mod 4 (lane 0 is bits 7:0). A frame's last word enables only the lanes that hold its bytes (enables 0001, 0011, 0111 or 1111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_err | input | 1 | MAC error flag, sampled with the last byte |
| rdptr_we | input | 1 | Write strobe for the read-pointer register |
| rdptr_wdata | input | 16 | New read-pointer register value (read offset − 16) |
| mem_we | output | 1 | Memory word write enable |
| mem_waddr | output | RING_AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_wbe | output | 4 | Per-byte write enables |
| rdptr_q | output | 16 | Read-pointer register value |
| wrptr | output | 16 | Committed write byte offset |
| buf_empty | output | 1 | Ring empty flag |
| irq_ok | output | 1 | Good-frame pulse |
| irq_err | output | 1 | Errored-frame pulse |
| missed | output | MISS_W | Dropped-frame counter (saturating) |

## Verification
The assertions assume two things about the MAC stream. A frame has at least two bytes, so its first beat is never also its last. At least one idle beat follows every last byte, so the final header write cannot meet the busy header of the next frame. The assertions also assume no frame is longer than MAX_FRAME. The stimulus sends only frames of 2 to MAX_FRAME bytes and inserts several idle cycles after each one, and it writes the read pointer only between frames.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam logic [15:0] LEN_BUSY   = 16'hFFF0;
  localparam logic [15:0] RDPTR_BIAS = 16'd16;
  localparam int ST_OK_BIT  = 0;
  localparam int ST_ERR_BIT = 1;

  typedef enum logic [1:0] {W_IDLE, W_DATA, W_DROP, W_SEAL} wstate_e;

  // lanes 0..lane enabled
  function automatic logic [3:0] lanes_upto(input logic [1:0] lane);
    logic [4:0] m;
    m = (5'd2 << lane) - 5'd1;
    return m[3:0];
  endfunction
endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
  parameter int RING_AW   = 13,
  parameter int MAX_FRAME = 1518
) (
  input  logic [RING_AW-1:0] wr_off,
  input  logic [RING_AW-1:0] rd_off,
  output logic               room
);
  localparam int RING_BYTES = 1 << RING_AW;
  localparam int NEED       = 4 + ((MAX_FRAME + 3) / 4) * 4;
  localparam logic [RING_AW:0] LIMIT = (RING_AW+1)'(RING_BYTES - NEED);

  logic [RING_AW-1:0] used;
  assign used = wr_off - rd_off;
  assign room = ({1'b0, used} < LIMIT);
endmodule

// File: rtl/rxring_packer.sv
module rxring_packer
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic [1:0]  lane,
  input  logic [7:0]  byte_in,
  output logic [31:0] word,
  output logic [3:0]  be
);
  logic [31:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (take) begin
      for (int i = 0; i < 4; i++) begin
        if (lane == 2'(i)) held[i*8 +: 8] <= byte_in;
      end
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < 4; i++) begin
      if (lane == 2'(i))     word[i*8 +: 8] = byte_in;
      else if (2'(i) < lane) word[i*8 +: 8] = held[i*8 +: 8];
    end
  end

  assign be = lanes_upto(lane);
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int RING_AW   = 13,
  parameter int MAX_FRAME = 1518,
  parameter int MISS_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 rx_last,
  input  logic                 rx_err,
  input  logic                 rdptr_we,
  input  logic [15:0]          rdptr_wdata,
  output logic                 mem_we,
  output logic [RING_AW-3:0]   mem_waddr,
  output logic [31:0]          mem_wdata,
  output logic [3:0]           mem_wbe,
  output logic [15:0]          rdptr_q,
  output logic [15:0]          wrptr,
  output logic                 buf_empty,
  output logic                 irq_ok,
  output logic                 irq_err,
  output logic [MISS_W-1:0]    missed
);
  localparam int WORD_AW = RING_AW - 2;
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  wstate_e             state;
  logic [15:0]         rdptr_r;
  logic [RING_AW-1:0]  rd_off;
  logic [RING_AW-1:0]  wp;
  logic [RING_AW-1:0]  cur_off;
  logic [WORD_AW-1:0]  hdr_word;
  logic [WORD_AW-1:0]  end_word;
  logic [15:0]         len_r;
  logic                err_r;
  logic                room;
  logic                pk_take;
  logic [1:0]          pk_lane;
  logic [31:0]         pk_word;
  logic [3:0]          pk_be;
  logic [15:0]         seal_status;

  // software read pointer, biased by 16
  always_ff @(posedge clk) begin
    if (rst)           rdptr_r <= 16'h0000 - RDPTR_BIAS;
    else if (rdptr_we) rdptr_r <= rdptr_wdata;
  end
  assign rd_off = RING_AW'(rdptr_r + RDPTR_BIAS);

  rxring_space #(.RING_AW(RING_AW), .MAX_FRAME(MAX_FRAME)) u_space (
    .wr_off (wp),
    .rd_off (rd_off),
    .room   (room)
  );

  assign pk_take = rx_valid && ((state == W_IDLE) ? room : (state == W_DATA));
  assign pk_lane = (state == W_DATA) ? cur_off[1:0] : 2'd0;

  rxring_packer u_pack (
    .clk     (clk),
    .rst     (rst),
    .take    (pk_take),
    .lane    (pk_lane),
    .byte_in (rx_byte),
    .word    (pk_word),
    .be      (pk_be)
  );

  always_comb begin
    seal_status = '0;
    seal_status[ST_OK_BIT]  = !err_r;
    seal_status[ST_ERR_BIT] = err_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      wp        <= '0;
      cur_off   <= '0;
      hdr_word  <= '0;
      end_word  <= '0;
      len_r     <= '0;
      err_r     <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      mem_wbe   <= '0;
      irq_ok    <= 1'b0;
      irq_err   <= 1'b0;
      missed    <= '0;
    end else begin
      mem_we  <= 1'b0;
      irq_ok  <= 1'b0;
      irq_err <= 1'b0;
      case (state)
        W_IDLE: begin
          if (rx_valid) begin
            if (room) begin
              mem_we    <= 1'b1;
              mem_waddr <= wp[RING_AW-1:2];
              mem_wdata <= {LEN_BUSY, 16'h0000};
              mem_wbe   <= 4'hF;
              hdr_word  <= wp[RING_AW-1:2];
              cur_off   <= wp + RING_AW'(5);
              len_r     <= 16'd1;
              state     <= W_DATA;
            end else begin
              if (missed != MISS_MAX) missed <= missed + MISS_W'(1);
              if (!rx_last) state <= W_DROP;
            end
          end
        end
        W_DATA: begin
          if (rx_valid) begin
            len_r   <= len_r + 16'd1;
            cur_off <= cur_off + RING_AW'(1);
            if (cur_off[1:0] == 2'd3 || rx_last) begin
              mem_we    <= 1'b1;
              mem_waddr <= cur_off[RING_AW-1:2];
              mem_wdata <= pk_word;
              mem_wbe   <= pk_be;
            end
            if (rx_last) begin
              err_r    <= rx_err;
              end_word <= cur_off[RING_AW-1:2] + WORD_AW'(1);
              state    <= W_SEAL;
            end
          end
        end
        W_SEAL: begin
          mem_we    <= 1'b1;
          mem_waddr <= hdr_word;
          mem_wdata <= {len_r, seal_status};
          mem_wbe   <= 4'hF;
          wp        <= {end_word, 2'b00};
          irq_ok    <= !err_r;
          irq_err   <= err_r;
          state     <= W_IDLE;
        end
        W_DROP: begin
          if (rx_valid && rx_last) state <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign rdptr_q   = rdptr_r;
  assign wrptr     = 16'(wp);
  assign buf_empty = (wp == rd_off);
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              mem_we,
  input logic [3:0]        mem_wbe,
  input logic [15:0]       wrptr,
  input logic              irq_ok,
  input logic              irq_err,
  input logic [MISS_W-1:0] missed
);
  logic in_frm;
  always_ff @(posedge clk) begin
    if (rst)           in_frm <= 1'b0;
    else if (rx_valid) in_frm <= !rx_last;
  end

  // R2 (input rule: idle beat after every last byte)
  ifg_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last) |=> !rx_valid);

  // R2 (input rule: a frame has at least two bytes)
  min_len_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !in_frm) |-> !rx_last);

  // R8
  irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_ok, irq_err}));

  // R8
  irq_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ok || irq_err) |-> (mem_we && mem_wbe == 4'hF));

  // R3
  wp_align_chk: assert property (@(posedge clk) disable iff (rst)
    wrptr[1:0] == 2'b00);

  // R3
  wp_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wrptr) |-> (irq_ok || irq_err));

  // R7
  miss_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (missed >= $past(missed)));

  // R9
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wbe == 4'h1 || mem_wbe == 4'h3 || mem_wbe == 4'h7 || mem_wbe == 4'hF));
endmodule

bind rxring_writer rxring_writer_chk #(.MISS_W(MISS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_valid (rx_valid),
  .rx_last  (rx_last),
  .mem_we   (mem_we),
  .mem_wbe  (mem_wbe),
  .wrptr    (wrptr),
  .irq_ok   (irq_ok),
  .irq_err  (irq_err),
  .missed   (missed)
);

// File: tb/rxring_writer_tb.sv
module rxring_writer_tb;
  localparam int RAW  = 8;
  localparam int RB   = 1 << RAW;
  localparam int MAXF = 40;
  localparam int MW   = 3;
  localparam int NEED = 4 + ((MAXF + 3) / 4) * 4;
  localparam int MISS_SAT = (1 << MW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rdptr_we = 1'b0;
  logic [15:0] rdptr_wdata = 16'h0000;
  logic mem_we;
  logic [RAW-3:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_wbe;
  logic [15:0] rdptr_q, wrptr;
  logic buf_empty, irq_ok, irq_err;
  logic [MW-1:0] missed;

  always #2 clk = ~clk;

  rxring_writer #(.RING_AW(RAW), .MAX_FRAME(MAXF), .MISS_W(MW)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_last(rx_last), .rx_err(rx_err), .rdptr_we(rdptr_we),
    .rdptr_wdata(rdptr_wdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_wbe(mem_wbe), .rdptr_q(rdptr_q),
    .wrptr(wrptr), .buf_empty(buf_empty), .irq_ok(irq_ok),
    .irq_err(irq_err), .missed(missed)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // memory seen by the design's write port, and the expected image
  logic [7:0] dmem [RB];
  logic [7:0] emem [RB];
  initial for (int i = 0; i < RB; i++) begin dmem[i] = 8'hA5; emem[i] = 8'hA5; end

  always @(posedge clk) begin
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_wbe[l]) dmem[int'(mem_waddr) * 4 + l] = mem_wdata[l*8 +: 8];
  end

  // behavioural reference model
  int m_state = 0, m_wp = 0, m_hdr = 0, m_off = 0, m_len = 0, m_rd = 16'hFFF0, m_missed = 0;
  bit m_err = 0, m_iok = 0, m_ierr = 0;

  function automatic int rdoff(input int r);
    return (r + 16) % RB;
  endfunction

  always @(posedge clk) begin
    m_iok = 0; m_ierr = 0;
    if (rst) begin
      m_state = 0; m_wp = 0; m_rd = 16'hFFF0; m_missed = 0;
    end else begin
      case (m_state)
        0: if (rx_valid) begin
          int used;
          used = ((m_wp - rdoff(m_rd)) % RB + RB) % RB;
          if (used < RB - NEED) begin
            m_hdr = m_wp;
            emem[m_hdr] = 8'h00; emem[m_hdr+1] = 8'h00;
            emem[m_hdr+2] = 8'hF0; emem[m_hdr+3] = 8'hFF;
            m_off = (m_wp + 4) % RB;
            emem[m_off] = rx_byte;
            m_off = (m_off + 1) % RB;
            m_len = 1;
            m_state = 1;
          end else begin
            if (m_missed < MISS_SAT) m_missed++;
            m_state = rx_last ? 0 : 2;
          end
        end
        1: if (rx_valid) begin
          emem[m_off] = rx_byte;
          m_off = (m_off + 1) % RB;
          m_len++;
          if (rx_last) begin m_err = rx_err; m_state = 3; end
        end
        3: begin
          emem[m_hdr]   = m_err ? 8'h02 : 8'h01;
          emem[m_hdr+1] = 8'h00;
          emem[m_hdr+2] = 8'(m_len);
          emem[m_hdr+3] = 8'(m_len >> 8);
          m_wp = (((m_off + 3) / 4) * 4) % RB;
          m_iok = !m_err; m_ierr = m_err;
          m_state = 0;
        end
        default: if (rx_valid && rx_last) m_state = 0;
      endcase
      if (rdptr_we) m_rd = rdptr_wdata;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (mon_on && !rst && !done) begin
      chk(wrptr == 16'(m_wp), "R3 wrptr", wrptr, m_wp);
      chk(buf_empty == (m_wp == rdoff(m_rd)), "R6 buf_empty", buf_empty, (m_wp == rdoff(m_rd)));
      chk(missed == MW'(m_missed), "R7 missed", missed, m_missed);
      chk(irq_ok == m_iok, "R8 irq_ok", irq_ok, m_iok);
      chk(irq_err == m_ierr, "R8 irq_err", irq_err, m_ierr);
      chk(rdptr_q == 16'(m_rd), "R5 rdptr_q", rdptr_q, m_rd);
    end
  end

  int seed = 1;

  task automatic send_frame(input int len, input bit err, input bit peek);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (peek && i == 3) begin
        chk(dmem[m_hdr+2] == 8'hF0 && dmem[m_hdr+3] == 8'hFF, "R2 busy header",
            {dmem[m_hdr+3], dmem[m_hdr+2]}, 16'hFFF0);
      end
      rx_valid = 1'b1;
      rx_byte  = 8'(seed * 29 + i * 13);
      rx_last  = (i == len - 1);
      rx_err   = err && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    repeat (4) @(negedge clk);
    seed++;
  endtask

  task automatic check_mem(input string what);
    int bad;
    int first;
    bad = 0; first = -1;
    for (int i = 0; i < RB; i++)
      if (dmem[i] !== emem[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1'b1, what, 0, 0);
    else chk(1'b0, what, dmem[first], emem[first]);
  endtask

  task automatic write_rd(input int val);
    @(negedge clk);
    rdptr_we = 1'b1; rdptr_wdata = 16'(val);
    @(negedge clk);
    rdptr_we = 1'b0;
  endtask

  task automatic consume_all;
    write_rd((m_wp - 16) & 16'hFFFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    // reset state
    chk(wrptr == 16'h0, "R3 reset wrptr", wrptr, 0);
    chk(buf_empty == 1'b1, "R6 reset empty", buf_empty, 1);
    chk(missed == '0, "R7 reset missed", missed, 0);
    chk(rdptr_q == 16'hFFF0, "R5 reset rdptr", rdptr_q, 16'hFFF0);
    chk(mem_we == 1'b0, "R2 reset no write", mem_we, 0);

    // good frame with partial last word, busy header seen mid-frame
    send_frame(10, 1'b0, 1'b1);
    check_mem("R1/R9 image after 10-byte frame");
    chk(wrptr == 16'd16, "R3 wrptr after 10 bytes", wrptr, 16);
    // errored frame
    send_frame(7, 1'b1, 1'b0);
    check_mem("R1 image after errored frame");
    chk(wrptr == 16'd28, "R3 wrptr after 7 bytes", wrptr, 28);
    chk(buf_empty == 1'b0, "R6 not empty", buf_empty, 0);
    consume_all();
    @(negedge clk);
    chk(buf_empty == 1'b1, "R6 empty after consume", buf_empty, 1);
    chk(rdptr_q == 16'd12, "R5 rdptr readback", rdptr_q, 12);

    // wrap-around: frames split across the ring end
    begin
      int prev;
      bit wrapped;
      wrapped = 0;
      for (int k = 0; k < 8; k++) begin
        prev = m_wp;
        send_frame(37 - k, k[0], 1'b0);
        check_mem("R4 image across wrap");
        if (m_wp < prev) wrapped = 1;
        consume_all();
      end
      chk(wrapped, "R4 write offset wrapped", wrapped, 1);
    end

    // fill without consuming until frames are refused
    for (int k = 0; k < 6; k++) send_frame(MAXF, 1'b0, 1'b0);
    check_mem("R7 image after refused frame");
    chk(missed == MW'(1), "R7 one frame missed", missed, 1);
    for (int k = 0; k < 9; k++) send_frame(2, 1'b0, 1'b0);
    check_mem("R7 refused frames leave memory");
    chk(missed == MW'(MISS_SAT), "R7 missed saturates", missed, MISS_SAT);

    // space returned: frames accepted again
    consume_all();
    send_frame(MAXF, 1'b1, 1'b1);
    send_frame(4, 1'b0, 1'b0);
    check_mem("R2/R9 image after recovery");
    chk(missed == MW'(MISS_SAT), "R7 missed held", missed, MISS_SAT);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule